// File: doc/BRIEF.md
# Triggered multi-channel ADC scan sequencer

This block is the digital control for a channel-scanning analog-to-digital converter. When enabled, it watches one of several external trigger lines, chosen by a 2-bit select. On a rising edge of that line it converts every channel set in a channel mask, one at a time, lowest index first. It stores each result in a register that belongs to that channel. After the last enabled channel it raises a one-cycle end-of-scan interrupt and re-arms for the next trigger.

The analog converter sits outside the block. The sequencer reaches it through a handshake: a one-cycle start pulse with a channel number, a busy input, and a done pulse that carries the result. A read port with one cycle of latency returns the stored result of any channel. A status output shows that a scan is in progress.

Top module: `adc_scan_seq`

## Requirements
- R1: Each trigger converts exactly the channels whose bit is set in `ch_mask`, in ascending index order. Disabled channels are skipped. `conv_ch` carries the channel number while `conv_start` is high.
- R2: The result of each completed conversion is written only to that channel's result register. Reading with `rd_ch` = k returns register k on `rd_data` one clock later. Registers of channels not converted in a scan keep their earlier contents.
- R3: `eos_irq` is a one-cycle pulse. It is raised once per scan, in the cycle after the done of the last enabled channel, and never after an intermediate channel.
- R4: `scanning` goes high the cycle after an accepted trigger edge. It goes low in the same cycle that `eos_irq` is raised, or when a scan is abandoned. After reset, `scanning`, `eos_irq` and `conv_start` are all low.
- R5: After a scan completes with `enable` still high, the next rising edge of the selected trigger starts the same scan again from the lowest enabled channel.
- R6: `trig_sel` = i selects `trig_in[i]` as the trigger source. Edges on the other trigger lines have no effect.
- R7: Only a rising edge of the selected trigger starts a scan. An edge that arrives while a scan is in progress is ignored. This includes an edge in the same cycle as the final done.
- R8: A trigger with an all-zero `ch_mask` issues no `conv_start`, raises no `eos_irq`, and leaves `scanning` low.
- R9: With `enable` low, triggers are ignored. If `enable` is cleared during a scan, the block waits for the done of the conversion in flight. It then returns to idle without writing that result, without starting further channels, and without raising `eos_irq`.
- R10: `conv_start` is a one-cycle pulse. It is issued only when `conv_busy` was low in the previous cycle. No new start is issued before the previous conversion's done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Sequencer enable |
| trig_sel | input | 2 | Selects which trigger line is used |
| trig_in | input | NUM_TRIG | External trigger lines |
| ch_mask | input | NUM_CH | Channel enable mask, captured at the trigger |
| conv_start | output | 1 | Start pulse to the converter |
| conv_ch | output | CH_W | Channel to be converted |
| conv_busy | input | 1 | Converter is busy |
| conv_done | input | 1 | Conversion finished; result is valid |
| conv_result | input | RES_W | Conversion result |
| rd_ch | input | CH_W | Result readback channel |
| rd_data | output | RES_W | Stored result for rd_ch, one cycle later |
| scanning | output | 1 | Scan in progress |
| eos_irq | output | 1 | End-of-scan interrupt pulse |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a new rising edge of the selected trigger and the done of the last channel in a scan. The bench raises the trigger at the falling edge where the model's done is already visible, using a single-channel mask. It then checks for exactly one interrupt and that no further start pulse follows. The second pair is the clearing of `enable` while a conversion is in flight. The bench judges that case by the start count, the absence of the interrupt, and readback showing that the in-flight channel's register kept its old value.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2
  } scan_state_t;
endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
  parameter int NUM_TRIG = 4,
  parameter int SEL_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SEL_W-1:0]    sel,
  input  logic [NUM_TRIG-1:0] lines,
  output logic                rise
);
  logic picked;
  logic picked_q;

  assign picked = lines[sel];

  always_ff @(posedge clk) begin
    if (rst) picked_q <= 1'b0;
    else     picked_q <= picked;
  end

  assign rise = picked & ~picked_q;
endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int NUM_CH = 6,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] mask,
  input  logic [CH_W-1:0]   cur,
  input  logic              from_start,
  output logic              found,
  output logic [CH_W-1:0]   nxt
);
  always_comb begin
    found = 1'b0;
    nxt   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (mask[i] && (from_start || (i > int'(cur)))) begin
        found = 1'b1;
        nxt   = CH_W'(i);
      end
    end
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NUM_CH = 6,
  parameter int RES_W  = 12,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_ch,
  input  logic [RES_W-1:0] wr_data,
  input  logic [CH_W-1:0]  rd_ch,
  output logic [RES_W-1:0] rd_data
);
  logic [RES_W-1:0] mem [NUM_CH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ch] <= wr_data;
    rd_data <= mem[rd_ch];
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH   = 6,
  parameter int RES_W    = 12,
  parameter int NUM_TRIG = 4,
  parameter int CH_W     = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic [1:0]          trig_sel,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic [NUM_CH-1:0]   ch_mask,
  output logic                conv_start,
  output logic [CH_W-1:0]     conv_ch,
  input  logic                conv_busy,
  input  logic                conv_done,
  input  logic [RES_W-1:0]    conv_result,
  input  logic [CH_W-1:0]     rd_ch,
  output logic [RES_W-1:0]    rd_data,
  output logic                scanning,
  output logic                eos_irq
);
  scan_state_t       state;
  logic [NUM_CH-1:0] scan_mask;
  logic [CH_W-1:0]   cur;
  logic              trig_rise;
  logic              pick_found;
  logic [CH_W-1:0]   pick_ch;
  logic              in_idle;
  logic              wr_en;

  assign in_idle = (state == S_IDLE);

  adc_trig_edge #(.NUM_TRIG(NUM_TRIG), .SEL_W(2)) u_edge (
    .clk(clk), .rst(rst), .sel(trig_sel), .lines(trig_in), .rise(trig_rise)
  );

  adc_chan_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
    .mask(in_idle ? ch_mask : scan_mask),
    .cur(cur),
    .from_start(in_idle),
    .found(pick_found),
    .nxt(pick_ch)
  );

  assign wr_en = (state == S_WAIT) && conv_done && enable;

  adc_result_bank #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W)) u_bank (
    .clk(clk), .wr_en(wr_en), .wr_ch(cur), .wr_data(conv_result),
    .rd_ch(rd_ch), .rd_data(rd_data)
  );

  assign conv_ch = cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      scan_mask  <= '0;
      cur        <= '0;
      conv_start <= 1'b0;
      scanning   <= 1'b0;
      eos_irq    <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      eos_irq    <= 1'b0;
      case (state)
        S_IDLE: begin
          if (enable && trig_rise && pick_found) begin
            scan_mask <= ch_mask;
            cur       <= pick_ch;
            scanning  <= 1'b1;
            state     <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          if (!enable) begin
            scanning <= 1'b0;
            state    <= S_IDLE;
          end else if (!conv_busy) begin
            conv_start <= 1'b1;
            state      <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (conv_done) begin
            if (!enable) begin
              scanning <= 1'b0;
              state    <= S_IDLE;
            end else if (pick_found) begin
              cur   <= pick_ch;
              state <= S_ISSUE;
            end else begin
              scanning <= 1'b0;
              eos_irq  <= 1'b1;
              state    <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int NUM_CH = 6,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic [NUM_CH-1:0] ch_mask,
  input logic [NUM_CH-1:0] scan_mask,
  input logic              conv_start,
  input logic [CH_W-1:0]   conv_ch,
  input logic              conv_busy,
  input logic              conv_done,
  input logic              scanning,
  input logic              eos_irq
);
  // R3: interrupt lasts a single cycle
  a_r3_irq_pulse: assert property (@(posedge clk) disable iff (rst)
    eos_irq |=> !eos_irq);

  // R3: interrupt only follows a converter done
  a_r3_irq_after_done: assert property (@(posedge clk) disable iff (rst)
    eos_irq |-> $past(conv_done));

  // R4: status is low when the interrupt fires
  a_r4_idle_at_irq: assert property (@(posedge clk) disable iff (rst)
    eos_irq |-> !scanning);

  // R10: start is a single-cycle pulse
  a_r10_start_pulse: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  // R10: start only when converter was idle
  a_r10_start_not_busy: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> !$past(conv_busy));

  // R1: every started channel is enabled in the captured mask
  a_r1_start_enabled: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> scan_mask[conv_ch]);

  // R8, R9: a scan only begins with enable high and a nonzero mask
  a_r8_scan_needs_mask: assert property (@(posedge clk) disable iff (rst)
    $rose(scanning) |-> ($past(enable) && ($past(ch_mask) != '0)));
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .ch_mask(ch_mask),
  .scan_mask(scan_mask), .conv_start(conv_start), .conv_ch(conv_ch),
  .conv_busy(conv_busy), .conv_done(conv_done), .scanning(scanning),
  .eos_irq(eos_irq)
);

// File: tb/adc_scan_seq_test.sv
`timescale 1ns/1ps
module adc_scan_seq_test;
  localparam int NUM_CH   = 6;
  localparam int RES_W    = 12;
  localparam int NUM_TRIG = 4;
  localparam int CH_W     = $clog2(NUM_CH);
  localparam int LAT      = 3;
  localparam int NVEC     = 7;
  // [15:8] mask, [7:6] trigger select, [5:0] seed
  localparam logic [15:0] VEC [NVEC] = '{
    {8'h2A, 2'd0, 6'd5},  {8'h3F, 2'd1, 6'd9},  {8'h01, 2'd2, 6'd12},
    {8'h20, 2'd3, 6'd3},  {8'h03, 2'd0, 6'd20}, {8'h11, 2'd2, 6'd40},
    {8'h00, 2'd1, 6'd7}
  };

  logic clk = 0, rst = 1, enable = 0;
  logic [1:0] trig_sel = 0;
  logic [NUM_TRIG-1:0] trig_in = 0;
  logic [NUM_CH-1:0] ch_mask = 0;
  logic conv_start, conv_busy, conv_done, scanning, eos_irq;
  logic [CH_W-1:0] conv_ch, rd_ch = 0, m_ch;
  logic [RES_W-1:0] conv_result, rd_data;

  int nchk = 0, nfail = 0, nstart, nirq, seed = 0, m_cnt;
  int log_ch [256];
  int exp_res [NUM_CH];

  always #2.5 clk = ~clk;

  adc_scan_seq #(.NUM_CH(NUM_CH), .RES_W(RES_W), .NUM_TRIG(NUM_TRIG)) uut (
    .clk(clk), .rst(rst), .enable(enable), .trig_sel(trig_sel),
    .trig_in(trig_in), .ch_mask(ch_mask), .conv_start(conv_start),
    .conv_ch(conv_ch), .conv_busy(conv_busy), .conv_done(conv_done),
    .conv_result(conv_result), .rd_ch(rd_ch), .rd_data(rd_data),
    .scanning(scanning), .eos_irq(eos_irq)
  );

  // converter model and event log
  always @(posedge clk) begin
    if (rst) begin
      conv_busy <= 0; conv_done <= 0; conv_result <= 0; m_cnt <= 0; m_ch <= 0;
      nstart <= 0; nirq <= 0;
    end else begin
      conv_done <= 0;
      if (conv_start) begin
        conv_busy <= 1; m_cnt <= LAT; m_ch <= conv_ch;
        if (nstart < 256) log_ch[nstart] <= int'(conv_ch);
        nstart <= nstart + 1;
      end else if (conv_busy) begin
        if (m_cnt == 0) begin
          conv_busy <= 0; conv_done <= 1;
          conv_result <= RES_W'(seed * 16 + int'(m_ch));
        end else m_cnt <= m_cnt - 1;
      end
      if (eos_irq) nirq <= nirq + 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(int line);
    @(negedge clk) trig_in[line] = 1;
    @(negedge clk);
    @(negedge clk) trig_in[line] = 0;
  endtask

  task automatic rd(int ch, output int val);
    @(negedge clk) rd_ch = CH_W'(ch);
    @(negedge clk) val = int'(rd_data);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int b, bi, v, k;
    for (int c = 0; c < NUM_CH; c++) exp_res[c] = -1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R4 reset scanning", int'(scanning), 0);
    chk("R4 reset irq", int'(eos_irq), 0);
    chk("R4 reset start", int'(conv_start), 0);
    enable = 1;

    // vector table: R1 R2 R3 R5 R6 R8
    for (int i = 0; i < NVEC; i++) begin
      ch_mask  = VEC[i][8 +: NUM_CH];
      trig_sel = VEC[i][7:6];
      seed     = int'(VEC[i][5:0]);
      b = nstart; bi = nirq;
      pulse((int'(trig_sel) + 1) % NUM_TRIG);
      idle(4);
      chk("R6 other line ignored", nstart - b, 0);
      pulse(int'(trig_sel));
      chk("R4 scanning during scan", int'(scanning), int'(ch_mask != 0));
      idle(80);
      chk("R4 scanning after scan", int'(scanning), 0);
      k = 0;
      for (int c = 0; c < NUM_CH; c++)
        if (ch_mask[c]) begin
          chk("R1 R5 channel order", log_ch[b + k], c);
          exp_res[c] = seed * 16 + c;
          k++;
        end
      chk("R1 R8 start count", nstart - b, k);
      chk("R3 R8 irq count", nirq - bi, int'(k != 0));
      for (int c = 0; c < NUM_CH; c++)
        if (exp_res[c] >= 0) begin
          rd(c, v);
          chk("R2 readback", v, exp_res[c]);
        end
    end

    // R7: second edge during a scan is ignored
    ch_mask = 6'b101010; trig_sel = 0; seed = 50;
    b = nstart; bi = nirq;
    pulse(0);
    idle(2);
    pulse(0);
    idle(80);
    chk("R7 retrigger ignored starts", nstart - b, 3);
    chk("R7 retrigger ignored irq", nirq - bi, 1);
    exp_res[1] = 801; exp_res[3] = 803; exp_res[5] = 805;

    // R7 R3: edge in the same cycle as the final done
    ch_mask = 6'b000100; seed = 61;
    b = nstart; bi = nirq;
    pulse(0);
    while (!conv_done) @(negedge clk);
    trig_in[0] = 1;
    idle(30);
    trig_in[0] = 0;
    idle(2);
    chk("R7 edge at final done starts", nstart - b, 1);
    chk("R3 edge at final done irq", nirq - bi, 1);
    exp_res[2] = 61 * 16 + 2;

    // R9: enable low ignores triggers
    enable = 0; ch_mask = 6'b111111; b = nstart;
    pulse(0);
    idle(10);
    chk("R9 disabled trigger", nstart - b, 0);

    // R8: zero mask with enable high
    enable = 1; ch_mask = 0; b = nstart; bi = nirq;
    pulse(0);
    chk("R8 zero mask scanning", int'(scanning), 0);
    idle(10);
    chk("R8 zero mask starts", nstart - b, 0);
    chk("R8 zero mask irq", nirq - bi, 0);

    // R9: clear enable mid-scan while channel 1 is in flight
    ch_mask = 6'b111111; seed = 33; b = nstart; bi = nirq;
    pulse(0);
    while (nstart - b < 2) @(negedge clk);
    enable = 0;
    idle(40);
    chk("R9 abandon starts", nstart - b, 2);
    chk("R9 abandon irq", nirq - bi, 0);
    chk("R9 abandon scanning", int'(scanning), 0);
    rd(0, v);
    chk("R9 channel 0 written", v, 33 * 16);
    rd(1, v);
    chk("R9 in-flight channel kept", v, exp_res[1]);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule